// File: doc/BRIEF.md
# DFI Low-Power Request Handler

This block sits in a memory PHY beside the controller-facing low-power handshake. A controller may offer a low-power opportunity on a control-side request line, a data-side request line, or both. When the block is idle and sees either request, it captures four things: the 4-bit encoded wakeup time offered with the request, the programmed wakeup threshold, and the two power-down enables. It then raises its acknowledge. While any request stays asserted it holds the byte in low power. The I/Os are powered down when the captured I/O enable is set. The PLL is powered down when the captured PLL enable is set and the captured wakeup code is strictly greater than the captured threshold.

Both the wakeup code and the threshold are logarithmic. Code n stands for 16·2^n clock cycles, so 0000 is 16 cycles and 1110 is 262144 cycles. Code 1111 stands for an unlimited wakeup time. When every request has dropped, the block powers the I/Os and the PLL back up. If the PLL was off, it keeps the acknowledge high until the PLL lock input reports relock, and only then releases it. A fresh request that arrives while the block waits for relock sends it straight back into low power with a newly captured session, and the acknowledge never drops.

The controller runs through five states:
- IDLE: no acknowledge and no power-down. A request moves it to LP_ENTER and captures the session.
- LP_ENTER: acknowledge only. A held request moves it to LP_ACTIVE. A request that has already gone moves it to EXIT.
- LP_ACTIVE: acknowledge plus the captured power-downs. When all requests drop, it moves to WAIT_RELOCK if the PLL was off, or to EXIT if it was not.
- WAIT_RELOCK: acknowledge with power restored. A new request takes it to LP_ENTER with a recapture. Otherwise a lock indication takes it to EXIT.
- EXIT: everything low for one cycle, then IDLE.

Top module: `lp_req_handler`

## Requirements
- R1: After reset, lp_ack, io_pwr_down and pll_pwr_down are all low.
- R2: From idle, an assertion of lp_ctrl_req or lp_data_req, either one alone or both, makes lp_ack high in the cycle after the clock edge that samples it. No power-down output is asserted in that first cycle.
- R3: One cycle after the acknowledge rises, provided a request is still held, io_pwr_down equals the captured I/O enable. In the same cycle pll_pwr_down is high exactly when the captured PLL enable is 1 and the captured 4-bit wakeup code, read as unsigned, exceeds the captured 4-bit threshold. Both outputs then stay stable while any request is held.
- R4: A wakeup code equal to the threshold does not power down the PLL. Example: code 1100 with threshold 1100 gives pll_pwr_down low.
- R5: With the PLL enable at 0, pll_pwr_down stays low even for wakeup code 1111 (unlimited) and threshold 0000.
- R6: If the PLL was not powered down, the edge that first samples all requests low makes lp_ack, io_pwr_down and pll_pwr_down low. This also covers a request that drops before low power was entered.
- R7: If the PLL was powered down, the edge that first samples all requests low makes io_pwr_down and pll_pwr_down low while lp_ack stays high. lp_ack falls on the edge that samples pll_locked high.
- R8: Changes to the wakeup code, threshold or enables while a session is held have no effect on the power-down outputs of that session.
- R9: A request sampled while waiting for relock takes priority over pll_locked. lp_ack stays high, a new session is captured, and one cycle later the power-down outputs follow the new session's captured values as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_ctrl_req | input | 1 | Control-side low-power opportunity request |
| lp_data_req | input | 1 | Data-side low-power opportunity request |
| lp_wake_code | input | 4 | Encoded wakeup time offered with the request (16·2^n cycles, 1111 unlimited) |
| cfg_wake_thresh | input | 4 | Threshold code the wakeup code must exceed for PLL power-down |
| cfg_pll_pd_en | input | 1 | Allow PLL power-down |
| cfg_io_pd_en | input | 1 | Allow I/O power-down |
| pll_locked | input | 1 | PLL lock indication |
| lp_ack | output | 1 | Low-power acknowledge |
| io_pwr_down | output | 1 | Power down the byte's I/Os |
| pll_pwr_down | output | 1 | Power down the byte's PLL |

## Verification
The assertions take for granted that requests and configuration change only between clock edges. They also assume that pll_locked eventually rises once the PLL is powered back up, so a relock wait always ends. The bench drives every input on the falling edge and samples on the following rising edge plus a small delay. It raises pll_locked only when it intends to end a relock wait, and in one case together with a new request to exercise the priority of R9. Configuration is deliberately changed in the middle of a held session, which the assertions allow, so that R8 is exercised.

// File: rtl/lp_req_pkg.sv
package lp_req_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_LP_ENTER    = 3'd1,
        ST_LP_ACTIVE   = 3'd2,
        ST_WAIT_RELOCK = 3'd3,
        ST_EXIT        = 3'd4
    } lp_state_e;

    // Log-scale codes: all-ones (unlimited) naturally compares above every
    // finite code, so a plain unsigned compare implements the rule.
    function automatic logic wake_exceeds(input logic [7:0] code,
                                          input logic [7:0] thresh);
        return code > thresh;
    endfunction

endpackage

// File: rtl/lp_session_capture.sv
module lp_session_capture #(
    parameter int            CODE_W     = 4,
    parameter logic [CODE_W-1:0] RST_THRESH = 4'b1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] wake_code,
    input  logic [CODE_W-1:0] wake_thresh,
    input  logic              pll_pd_en,
    input  logic              io_pd_en,
    output logic              pll_go,
    output logic              io_go
);
    import lp_req_pkg::*;

    localparam int PAD_W = 8 - CODE_W;

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] thresh_q;
    logic              pll_en_q;
    logic              io_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            thresh_q <= RST_THRESH;
            pll_en_q <= 1'b1;
            io_en_q  <= 1'b1;
        end else if (load) begin
            code_q   <= wake_code;
            thresh_q <= wake_thresh;
            pll_en_q <= pll_pd_en;
            io_en_q  <= io_pd_en;
        end
    end

    always_comb begin
        pll_go = pll_en_q && wake_exceeds({{PAD_W{1'b0}}, code_q},
                                          {{PAD_W{1'b0}}, thresh_q});
        io_go  = io_en_q;
    end

    // R8: without a load the session decision cannot move
    a_r8_session_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(pll_go) && $stable(io_go)));

endmodule

// File: rtl/lp_ctrl_fsm.sv
module lp_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_any,
    input  logic pll_go,
    input  logic io_go,
    input  logic pll_locked,
    output logic cap_load,
    output logic ack,
    output logic io_pd,
    output logic pll_pd
);
    import lp_req_pkg::*;

    lp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cap_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_any) begin
                    state_d  = ST_LP_ENTER;
                    cap_load = 1'b1;
                end
            end
            ST_LP_ENTER: begin
                state_d = req_any ? ST_LP_ACTIVE : ST_EXIT;
            end
            ST_LP_ACTIVE: begin
                if (!req_any) state_d = pll_go ? ST_WAIT_RELOCK : ST_EXIT;
            end
            ST_WAIT_RELOCK: begin
                if (req_any) begin
                    state_d  = ST_LP_ENTER;
                    cap_load = 1'b1;
                end else if (pll_locked) begin
                    state_d = ST_EXIT;
                end
            end
            ST_EXIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ack    = 1'b0;
        io_pd  = 1'b0;
        pll_pd = 1'b0;
        unique case (state_q)
            ST_IDLE:        ;
            ST_LP_ENTER:    ack = 1'b1;
            ST_LP_ACTIVE: begin
                ack    = 1'b1;
                io_pd  = io_go;
                pll_pd = pll_go;
            end
            ST_WAIT_RELOCK: ack = 1'b1;
            ST_EXIT:        ;
            default:        ;
        endcase
    end

    // R2: a request seen in idle is acknowledged on the next cycle
    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_any) |=> ack);

    // R7: while relock is pending and no lock is seen, ack holds and power stays on
    a_r7_hold_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RELOCK && !req_any && !pll_locked)
        |=> (ack && !pll_pd && !io_pd));

    // R9: a request during relock never lets ack drop
    a_r9_reentry_keeps_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_RELOCK && req_any) |=> (ack && !io_pd && !pll_pd));

endmodule

// File: rtl/lp_req_handler.sv
module lp_req_handler #(
    parameter int                CODE_W     = 4,
    parameter logic [CODE_W-1:0] RST_THRESH = 4'b1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_ctrl_req,
    input  logic              lp_data_req,
    input  logic [CODE_W-1:0] lp_wake_code,
    input  logic [CODE_W-1:0] cfg_wake_thresh,
    input  logic              cfg_pll_pd_en,
    input  logic              cfg_io_pd_en,
    input  logic              pll_locked,
    output logic              lp_ack,
    output logic              io_pwr_down,
    output logic              pll_pwr_down
);
    logic req_any;
    logic cap_load;
    logic pll_go;
    logic io_go;

    assign req_any = lp_ctrl_req | lp_data_req;

    lp_session_capture #(
        .CODE_W     (CODE_W),
        .RST_THRESH (RST_THRESH)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cap_load),
        .wake_code   (lp_wake_code),
        .wake_thresh (cfg_wake_thresh),
        .pll_pd_en   (cfg_pll_pd_en),
        .io_pd_en    (cfg_io_pd_en),
        .pll_go      (pll_go),
        .io_go       (io_go)
    );

    lp_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_any    (req_any),
        .pll_go     (pll_go),
        .io_go      (io_go),
        .pll_locked (pll_locked),
        .cap_load   (cap_load),
        .ack        (lp_ack),
        .io_pd      (io_pwr_down),
        .pll_pd     (pll_pwr_down)
    );

    // R3: power-down is only ever asserted under an acknowledge
    a_r3_pd_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (io_pwr_down || pll_pwr_down) |-> lp_ack);

    // R7: the PLL always comes back up before the acknowledge is released
    a_r7_pll_up_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_pwr_down) |-> lp_ack);

    // R6: power-down never drops while a request is still held
    a_r6_no_early_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (io_pwr_down && req_any) |=> (io_pwr_down || !lp_ack || !req_any));

endmodule

// File: tb/lp_req_handler_tb.sv
module lp_req_handler_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_ctrl_req = 1'b0;
    logic       lp_data_req = 1'b0;
    logic [3:0] lp_wake_code = 4'd0;
    logic [3:0] cfg_wake_thresh = 4'b1100;
    logic       cfg_pll_pd_en = 1'b1;
    logic       cfg_io_pd_en = 1'b1;
    logic       pll_locked = 1'b0;
    logic       lp_ack, io_pwr_down, pll_pwr_down;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_req_handler u_dut (
        .clk(clk), .rst_n(rst_n),
        .lp_ctrl_req(lp_ctrl_req), .lp_data_req(lp_data_req),
        .lp_wake_code(lp_wake_code), .cfg_wake_thresh(cfg_wake_thresh),
        .cfg_pll_pd_en(cfg_pll_pd_en), .cfg_io_pd_en(cfg_io_pd_en),
        .pll_locked(pll_locked),
        .lp_ack(lp_ack), .io_pwr_down(io_pwr_down), .pll_pwr_down(pll_pwr_down)
    );

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ack,io,pll} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {lp_ack, io_pwr_down, pll_pwr_down};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [3:0] code, input logic [3:0] th,
                           input logic pen, input logic ien);
        lp_wake_code    = code;
        cfg_wake_thresh = th;
        cfg_pll_pd_en   = pen;
        cfg_io_pd_en    = ien;
    endtask

    // Enter a session and check the ack cycle and the power-down cycle.
    task automatic enter(input string tag, input logic c, input logic d,
                         input logic [3:0] code, input logic [3:0] th,
                         input logic pen, input logic ien, input logic [2:0] exp_pd);
        @(negedge clk);
        set_cfg(code, th, pen, ien);
        lp_ctrl_req = c;
        lp_data_req = d;
        step();
        chk({tag, " R2 ack"}, outs(), 3'b100);
        step();
        chk({tag, " R3 pd"}, outs(), exp_pd);
    endtask

    task automatic drop_no_pll(input string tag);
        @(negedge clk);
        lp_ctrl_req = 1'b0;
        lp_data_req = 1'b0;
        step();
        chk({tag, " R6 exit"}, outs(), 3'b000);
        step();
        chk({tag, " R6 idle"}, outs(), 3'b000);
    endtask

    task automatic drop_with_relock(input string tag);
        @(negedge clk);
        lp_ctrl_req = 1'b0;
        lp_data_req = 1'b0;
        step();
        chk({tag, " R7 wait"}, outs(), 3'b100);
        for (int i = 0; i < 4; i++) begin
            step();
            chk({tag, " R7 hold"}, outs(), 3'b100);
        end
        @(negedge clk);
        pll_locked = 1'b1;
        step();
        chk({tag, " R7 release"}, outs(), 3'b000);
        @(negedge clk);
        pll_locked = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 in reset", outs(), 3'b000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", outs(), 3'b000);
    endtask

    task automatic t_pll_session_and_r8();
        enter("pll", 1, 0, 4'b1101, 4'b1100, 1, 1, 3'b111);
        @(negedge clk);
        set_cfg(4'b0000, 4'b1111, 0, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 mid-session cfg", outs(), 3'b111);
        end
        drop_with_relock("pll");
    endtask

    task automatic t_equal_threshold();
        enter("R4 equal", 0, 1, 4'b1100, 4'b1100, 1, 1, 3'b110);
        drop_no_pll("R4 equal");
    endtask

    task automatic t_pll_disabled();
        enter("R5 disabled", 1, 0, 4'b1111, 4'b0000, 0, 1, 3'b110);
        drop_no_pll("R5 disabled");
        enter("R3 io off", 1, 1, 4'b1111, 4'b1110, 1, 0, 3'b101);
        drop_with_relock("R3 io off");
    endtask

    task automatic t_relock_reentry();
        enter("R9 first", 1, 0, 4'b1110, 4'b0011, 1, 1, 3'b111);
        @(negedge clk);
        lp_ctrl_req = 1'b0;
        step();
        chk("R9 wait", outs(), 3'b100);
        @(negedge clk);
        set_cfg(4'b0001, 4'b1100, 1, 1);
        lp_data_req = 1'b1;
        pll_locked  = 1'b1;
        step();
        chk("R9 ack kept", outs(), 3'b100);
        @(negedge clk);
        pll_locked = 1'b0;
        step();
        chk("R9 new session", outs(), 3'b110);
        drop_no_pll("R9 end");
    endtask

    task automatic t_partial_drop();
        enter("R3 both", 1, 1, 4'b0010, 4'b0001, 1, 1, 3'b111);
        @(negedge clk);
        lp_ctrl_req = 1'b0;
        step();
        chk("R3 one req left", outs(), 3'b111);
        drop_with_relock("R3 both");
    endtask

    task automatic t_short_request();
        @(negedge clk);
        set_cfg(4'b1111, 4'b0000, 1, 1);
        lp_ctrl_req = 1'b1;
        step();
        chk("R2 short ack", outs(), 3'b100);
        @(negedge clk);
        lp_ctrl_req = 1'b0;
        step();
        chk("R6 short exit", outs(), 3'b000);
        step();
        chk("R6 short idle", outs(), 3'b000);
    endtask

    initial begin
        t_reset();
        t_pll_session_and_r8();
        t_equal_threshold();
        t_pll_disabled();
        t_relock_reentry();
        t_partial_drop();
        t_short_request();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule